// File: doc/BRIEF.md
# Mixed-Size Page Table Walker

This block turns a virtual address, tagged with a task identifier, into a physical address by reading a three-level translation table in memory. Each table entry carries its own leaf flag, so a walk can end at the first level (huge page), at the second (big page) or at the third (small page). Page size is therefore decided entry by entry. No global mode sets it. The task identifier picks the table root from a small bank of root registers that software loads through a write port.

A requester offers one translation at a time under a valid/ready handshake. The walker then issues table reads on a synchronous port with a fixed one-cycle latency. It returns the physical address, the page size that was resolved and a fault flag with the level at which the walk failed, and it holds that result until the requester takes it.

Top module: `mixed_page_walker`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0 and mem_rd_en is 0.
- R2: A write with root_we=1 stores root_ppn as the root table frame of task root_task. A walk for a task starts at that task's root, so two tasks with different roots translate the same address through different tables.
- R3: The index used at level L is a 9-bit slice of the virtual address: va[38:30] at level 1, va[29:21] at level 2 and va[20:12] at level 3. The entry address is {table_ppn, 12'b0} + 8*index.
- R4: Entries are 64 bits wide. Bit 0 is valid, bit 1 is leaf and bits [39:12] are the 28-bit frame number. A non-leaf entry's frame number is the base of the next table.
- R5: A valid leaf at level 1 ends the walk after one read with resp_size=2 (huge) and resp_pa={ppn[27:18], va[29:0]}.
- R6: A valid leaf at level 2 ends the walk after two reads with resp_size=1 (big) and resp_pa={ppn[27:9], va[20:0]}.
- R7: A valid level-3 entry always ends the walk, whatever its leaf bit. The walk then takes three reads and returns resp_size=0 (small) and resp_pa={ppn, va[11:0]}.
- R8: An entry whose valid bit is clear ends the walk with resp_fault=1 and resp_fault_lvl equal to the level (1, 2 or 3), and resp_pa=0. No further read is issued.
- R9: mem_rdata is used in the cycle after mem_rd_en. Only one read is ever outstanding. resp_valid rises two cycles after the last mem_rd_en, so the time from acceptance to response is two cycles per read.
- R10: req_ready is 1 only while the walker is idle. While resp_valid=1 and resp_ready=0, the response fields stay stable and no read is issued. The cycle after the response is taken, req_ready is 1 again.
- R11: If a root write and a request acceptance for the same task fall on the same clock edge, the request uses the old root. The next request uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| root_we | input | 1 | Root register write strobe |
| root_task | input | 8 | Task whose root is written |
| root_ppn | input | 28 | Root table frame number to store |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_task | input | 8 | Task identifier of the request |
| req_va | input | 39 | Virtual address of the request |
| resp_valid | output | 1 | Result available |
| resp_ready | input | 1 | Requester takes the result |
| resp_pa | output | 40 | Translated physical address (0 on fault) |
| resp_size | output | 2 | 0 small, 1 big, 2 huge |
| resp_fault | output | 1 | Walk hit an invalid entry |
| resp_fault_lvl | output | 2 | Level of the invalid entry, 0 when no fault |
| mem_rd_en | output | 1 | Table read strobe |
| mem_addr | output | 40 | Byte address of the table entry |
| mem_rdata | input | 64 | Entry returned one cycle after the strobe |

## Verification
Two functions can meet on one clock edge: a software write to a task's root register, and the acceptance of a request for that same task. The bench drives root_we and req_valid together on one edge. The old root's table and the new root's table each hold a huge leaf with its own distinct frame, so resp_pa shows which root the walk used. The request on that edge must give the old frame, and the request after it must give the new one.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int LEVELS = 3;

  typedef enum logic [1:0] {
    PG_SMALL = 2'd0,
    PG_BIG   = 2'd1,
    PG_HUGE  = 2'd2
  } page_size_e;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_ISSUE = 2'd1,
    W_WAIT  = 2'd2,
    W_DONE  = 2'd3
  } walk_state_e;
endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/ptw_root_regs.sv
module ptw_root_regs #(
  parameter int TASK_W = 8,
  parameter int PPN_W  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TASK_W-1:0] wr_task,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [TASK_W-1:0] rd_task,
  output logic [PPN_W-1:0]  rd_ppn
);
  localparam int NUM_TASKS = 1 << TASK_W;

  logic [PPN_W-1:0] root_q [NUM_TASKS];

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_root
    logic slot_en;
    assign slot_en = wr_en && (wr_task == TASK_W'(t));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        root_q[t] <= '0;
      end else if (slot_en) begin
        root_q[t] <= wr_ppn;
      end
    end
  end

  // read sees the value before any write on the same edge (R11)
  assign rd_ppn = root_q[rd_task];
endmodule

// File: rtl/ptw_level_decode.sv
module ptw_level_decode
  import ptw_pkg::*;
#(
  parameter int VA_W  = 39,
  parameter int PA_W  = 40,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12,
  parameter int ENT_W = 64
) (
  input  logic [1:0]            lvl,
  input  logic [VA_W-1:0]       va,
  input  logic [PA_W-OFF_W-1:0] base_ppn,
  input  logic [ENT_W-1:0]      entry,
  output logic [PA_W-1:0]       rd_addr,
  output logic                  ent_valid,
  output logic                  ent_leaf,
  output logic [PA_W-OFF_W-1:0] ent_ppn,
  output logic [PA_W-1:0]       leaf_pa,
  output page_size_e            leaf_size
);
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int ENT_SH = $clog2(ENT_W / 8);
  localparam logic [PA_W-1:0] ONE = PA_W'(1);

  logic [IDX_W-1:0] idx_tab  [LEVELS+1];
  logic [PA_W-1:0]  mask_tab [LEVELS+1];

  assign idx_tab[0]  = '0;
  assign mask_tab[0] = '0;

  for (genvar g = 1; g <= LEVELS; g++) begin : g_level
    localparam int LOW = OFF_W + (LEVELS - g) * IDX_W;
    assign idx_tab[g]  = va[LOW +: IDX_W];
    assign mask_tab[g] = (ONE << LOW) - ONE;
  end

  logic [IDX_W-1:0] idx_sel;
  logic [PA_W-1:0]  mask_sel;
  logic [PA_W-1:0]  frame;
  logic [PA_W-1:0]  va_ext;

  assign idx_sel  = idx_tab[lvl];
  assign mask_sel = mask_tab[lvl];

  assign rd_addr = {base_ppn, {OFF_W{1'b0}}} + (PA_W'(idx_sel) << ENT_SH);

  assign ent_valid = entry[0];
  assign ent_leaf  = entry[1] | (lvl == 2'(LEVELS));
  assign ent_ppn   = entry[OFF_W +: PPN_W];

  assign frame   = {ent_ppn, {OFF_W{1'b0}}};
  assign va_ext  = PA_W'(va);
  assign leaf_pa = (frame & ~mask_sel) | (va_ext & mask_sel);

  always_comb begin
    unique case (lvl)
      2'd1:    leaf_size = PG_HUGE;
      2'd2:    leaf_size = PG_BIG;
      default: leaf_size = PG_SMALL;
    endcase
  end

  logic unused_entry_bits;
  assign unused_entry_bits = ^{entry[ENT_W-1:OFF_W+PPN_W], entry[OFF_W-1:2]};
endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
  import ptw_pkg::*;
#(
  parameter int VA_W  = 39,
  parameter int PA_W  = 40,
  parameter int PPN_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [PPN_W-1:0] root_ppn,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [PA_W-1:0]  resp_pa,
  output logic [1:0]       resp_size,
  output logic             resp_fault,
  output logic [1:0]       resp_fault_lvl,
  output logic             mem_rd_en,
  output logic [1:0]       lvl,
  output logic [VA_W-1:0]  va,
  output logic [PPN_W-1:0] base_ppn,
  input  logic             ent_valid,
  input  logic             ent_leaf,
  input  logic [PPN_W-1:0] ent_ppn,
  input  logic [PA_W-1:0]  leaf_pa,
  input  page_size_e       leaf_size
);
  walk_state_e state_q, state_d;
  logic [1:0]       lvl_q, lvl_d;
  logic [VA_W-1:0]  va_q;
  logic [PPN_W-1:0] base_q, base_d;
  logic [PA_W-1:0]  pa_q, pa_d;
  logic [1:0]       size_q, size_d;
  logic             fault_q, fault_d;
  logic [1:0]       flvl_q, flvl_d;

  logic load_req;
  logic step_en;
  logic res_en;

  always_comb begin
    state_d  = state_q;
    lvl_d    = lvl_q;
    base_d   = base_q;
    pa_d     = pa_q;
    size_d   = size_q;
    fault_d  = fault_q;
    flvl_d   = flvl_q;
    load_req = 1'b0;
    step_en  = 1'b0;
    res_en   = 1'b0;
    unique case (state_q)
      W_IDLE: begin
        if (req_valid) begin
          load_req = 1'b1;
          step_en  = 1'b1;
          lvl_d    = 2'd1;
          base_d   = root_ppn;
          state_d  = W_ISSUE;
        end
      end
      W_ISSUE: state_d = W_WAIT;
      W_WAIT: begin
        if (!ent_valid) begin
          res_en  = 1'b1;
          fault_d = 1'b1;
          flvl_d  = lvl_q;
          pa_d    = '0;
          size_d  = PG_SMALL;
          state_d = W_DONE;
        end else if (ent_leaf) begin
          res_en  = 1'b1;
          fault_d = 1'b0;
          flvl_d  = 2'd0;
          pa_d    = leaf_pa;
          size_d  = leaf_size;
          state_d = W_DONE;
        end else begin
          step_en = 1'b1;
          lvl_d   = lvl_q + 2'd1;
          base_d  = ent_ppn;
          state_d = W_ISSUE;
        end
      end
      W_DONE: begin
        if (resp_ready) state_d = W_IDLE;
      end
      default: state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      lvl_q   <= '0;
      va_q    <= '0;
      base_q  <= '0;
      pa_q    <= '0;
      size_q  <= '0;
      fault_q <= 1'b0;
      flvl_q  <= '0;
    end else begin
      state_q <= state_d;
      if (load_req) va_q <= req_va;
      if (step_en) begin
        lvl_q  <= lvl_d;
        base_q <= base_d;
      end
      if (res_en) begin
        pa_q    <= pa_d;
        size_q  <= size_d;
        fault_q <= fault_d;
        flvl_q  <= flvl_d;
      end
    end
  end

  assign req_ready      = (state_q == W_IDLE);
  assign resp_valid     = (state_q == W_DONE);
  assign mem_rd_en      = (state_q == W_ISSUE);
  assign resp_pa        = pa_q;
  assign resp_size      = size_q;
  assign resp_fault     = fault_q;
  assign resp_fault_lvl = flvl_q;
  assign lvl            = lvl_q;
  assign va             = va_q;
  assign base_ppn       = base_q;

  // R9: a read is never followed directly by another read
  assert_single_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R9: the result appears two cycles after the final read strobe
  assert_done_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) |-> $past(mem_rd_en, 2));

  // R10: a pending result blocks new requests
  assert_busy_no_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);

  // R10: a stalled result is held unchanged
  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_pa) &&
      $stable(resp_size) && $stable(resp_fault) && $stable(resp_fault_lvl)));

  // R8: every fault names a level
  assert_fault_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_fault_lvl != 2'd0));

  // R7: a valid third-level entry always finishes the walk
  assert_last_level_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == W_WAIT && lvl_q == 2'd3 && ent_valid) |=> resp_valid);
endmodule

// File: rtl/mixed_page_walker.sv
module mixed_page_walker
  import ptw_pkg::*;
#(
  parameter int TASK_W = 8,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 40,
  parameter int ENT_W  = 64,
  parameter int VA_W   = LEVELS * IDX_W + OFF_W,
  parameter int PPN_W  = PA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              root_we,
  input  logic [TASK_W-1:0] root_task,
  input  logic [PPN_W-1:0]  root_ppn,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TASK_W-1:0] req_task,
  input  logic [VA_W-1:0]   req_va,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [PA_W-1:0]   resp_pa,
  output logic [1:0]        resp_size,
  output logic              resp_fault,
  output logic [1:0]        resp_fault_lvl,
  output logic              mem_rd_en,
  output logic [PA_W-1:0]   mem_addr,
  input  logic [ENT_W-1:0]  mem_rdata
);
  logic             rst_i_n;
  logic [PPN_W-1:0] root_rd;
  logic [1:0]       lvl;
  logic [VA_W-1:0]  va;
  logic [PPN_W-1:0] base_ppn;
  logic             ent_valid;
  logic             ent_leaf;
  logic [PPN_W-1:0] ent_ppn;
  logic [PA_W-1:0]  leaf_pa;
  page_size_e       leaf_size;

  ptw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  ptw_root_regs #(.TASK_W(TASK_W), .PPN_W(PPN_W)) u_roots (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_en   (root_we),
    .wr_task (root_task),
    .wr_ppn  (root_ppn),
    .rd_task (req_task),
    .rd_ppn  (root_rd)
  );

  ptw_level_decode #(
    .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ENT_W(ENT_W)
  ) u_dec (
    .lvl       (lvl),
    .va        (va),
    .base_ppn  (base_ppn),
    .entry     (mem_rdata),
    .rd_addr   (mem_addr),
    .ent_valid (ent_valid),
    .ent_leaf  (ent_leaf),
    .ent_ppn   (ent_ppn),
    .leaf_pa   (leaf_pa),
    .leaf_size (leaf_size)
  );

  ptw_walk_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .PPN_W(PPN_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_i_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_va         (req_va),
    .root_ppn       (root_rd),
    .resp_valid     (resp_valid),
    .resp_ready     (resp_ready),
    .resp_pa        (resp_pa),
    .resp_size      (resp_size),
    .resp_fault     (resp_fault),
    .resp_fault_lvl (resp_fault_lvl),
    .mem_rd_en      (mem_rd_en),
    .lvl            (lvl),
    .va             (va),
    .base_ppn       (base_ppn),
    .ent_valid      (ent_valid),
    .ent_leaf       (ent_leaf),
    .ent_ppn        (ent_ppn),
    .leaf_pa        (leaf_pa),
    .leaf_size      (leaf_size)
  );

  // R1: while reset is held, the walker sits idle with no read pending
  always_ff @(posedge clk) begin
    if (!rst_i_n) begin
      assert_reset_idle_R1: assert (!resp_valid && !mem_rd_en);
    end
  end
endmodule

// File: tb/mixed_page_walker_test.sv
module mixed_page_walker_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        root_we;
  logic [7:0]  root_task;
  logic [27:0] root_ppn;
  logic        req_valid;
  logic        req_ready;
  logic [7:0]  req_task;
  logic [38:0] req_va;
  logic        resp_valid;
  logic        resp_ready;
  logic [39:0] resp_pa;
  logic [1:0]  resp_size;
  logic        resp_fault;
  logic [1:0]  resp_fault_lvl;
  logic        mem_rd_en;
  logic [39:0] mem_addr;
  logic [63:0] mem_rdata;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;

  logic [63:0] mem [logic [39:0]];

  always #10 clk = ~clk;

  mixed_page_walker uut (
    .clk(clk), .rst_n(rst_n),
    .root_we(root_we), .root_task(root_task), .root_ppn(root_ppn),
    .req_valid(req_valid), .req_ready(req_ready), .req_task(req_task), .req_va(req_va),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_pa(resp_pa),
    .resp_size(resp_size), .resp_fault(resp_fault), .resp_fault_lvl(resp_fault_lvl),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_rd_en) begin
      rd_cnt = rd_cnt + 1;
      mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
    end
  end

  function automatic logic [63:0] ent(input logic v, input logic leaf, input logic [27:0] ppn);
    return {24'h0, ppn, 10'h0, leaf, v};
  endfunction

  function automatic logic [39:0] eaddr(input logic [27:0] tbl, input logic [8:0] idx);
    return {tbl, 12'h0} + {28'h0, idx, 3'b000};
  endfunction

  function automatic logic [38:0] mkva(input logic [8:0] a, input logic [8:0] b,
                                       input logic [8:0] c, input logic [11:0] off);
    return {a, b, c, off};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_root(input logic [7:0] t, input logic [27:0] p);
    @(negedge clk);
    root_we = 1'b1; root_task = t; root_ppn = p;
    @(negedge clk);
    root_we = 1'b0;
  endtask

  task automatic take_resp(input string req);
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    chk(req, "ready after take", {63'h0, req_ready}, 64'h1);
  endtask

  // issue one request; returns when the response is visible (not yet taken)
  task automatic walk(input logic [7:0] t, input logic [38:0] v, output int lat);
    @(negedge clk);
    rd_cnt = 0;
    req_valid = 1'b1; req_task = t; req_va = v;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!resp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset;
    chk("R1", "req_ready", {63'h0, req_ready}, 64'h1);
    chk("R1", "resp_valid", {63'h0, resp_valid}, 64'h0);
    chk("R1", "mem_rd_en", {63'h0, mem_rd_en}, 64'h0);
  endtask

  task automatic t_small;
    int lat;
    logic [38:0] v = mkva(9'd3, 9'd4, 9'd5, 12'hABC);
    mem[eaddr(28'h100, 9'd3)] = ent(1'b1, 1'b0, 28'h300);
    mem[eaddr(28'h300, 9'd4)] = ent(1'b1, 1'b0, 28'h400);
    mem[eaddr(28'h400, 9'd5)] = ent(1'b1, 1'b0, 28'h1234567);
    walk(8'd5, v, lat);
    chk("R7", "small pa", {24'h0, resp_pa}, {24'h0, 28'h1234567, 12'hABC});
    chk("R7", "small size", {62'h0, resp_size}, 64'h0);
    chk("R7", "small reads", 64'(rd_cnt), 64'd3);
    chk("R9", "small latency", 64'(lat), 64'd6);
    chk("R3", "no fault", {63'h0, resp_fault}, 64'h0);
    take_resp("R10");
    // level-3 leaf bit set: same outcome (R7)
    mem[eaddr(28'h400, 9'd6)] = ent(1'b1, 1'b1, 28'h0FEDCBA);
    walk(8'd5, mkva(9'd3, 9'd4, 9'd6, 12'h001), lat);
    chk("R7", "leaf-bit small pa", {24'h0, resp_pa}, {24'h0, 28'h0FEDCBA, 12'h001});
    chk("R4", "leaf-bit small size", {62'h0, resp_size}, 64'h0);
    take_resp("R10");
  endtask

  task automatic t_big;
    int lat;
    logic [38:0] v = mkva(9'd7, 9'd8, 9'h1A5, 12'h5C3);
    logic [27:0] fp = 28'hABCDE55;
    mem[eaddr(28'h100, 9'd7)] = ent(1'b1, 1'b0, 28'h500);
    mem[eaddr(28'h500, 9'd8)] = ent(1'b1, 1'b1, fp);
    walk(8'd5, v, lat);
    chk("R6", "big pa", {24'h0, resp_pa}, {24'h0, fp[27:9], v[20:0]});
    chk("R6", "big size", {62'h0, resp_size}, 64'h1);
    chk("R6", "big reads", 64'(rd_cnt), 64'd2);
    chk("R9", "big latency", 64'(lat), 64'd4);
    take_resp("R10");
  endtask

  task automatic t_huge;
    int lat;
    logic [38:0] v = mkva(9'd1, 9'h1FF, 9'h0AA, 12'h777);
    logic [27:0] fp = 28'h7654321;
    mem[eaddr(28'h200, 9'd1)] = ent(1'b1, 1'b1, fp);
    walk(8'd9, v, lat);
    chk("R5", "huge pa", {24'h0, resp_pa}, {24'h0, fp[27:18], v[29:0]});
    chk("R5", "huge size", {62'h0, resp_size}, 64'h2);
    chk("R5", "huge reads", 64'(rd_cnt), 64'd1);
    chk("R9", "huge latency", 64'(lat), 64'd2);
    take_resp("R10");
    // same address on task 5 uses another root: entry absent -> level-1 fault (R2)
    walk(8'd5, v, lat);
    chk("R2", "other task faults", {63'h0, resp_fault}, 64'h1);
    chk("R8", "level-1 fault lvl", {62'h0, resp_fault_lvl}, 64'h1);
    chk("R8", "level-1 fault pa", {24'h0, resp_pa}, 64'h0);
    chk("R8", "level-1 fault reads", 64'(rd_cnt), 64'd1);
    take_resp("R10");
  endtask

  task automatic t_faults;
    int lat;
    // level 2 invalid under existing level-1 pointer idx 3
    walk(8'd5, mkva(9'd3, 9'd9, 9'd0, 12'h0), lat);
    chk("R8", "level-2 fault", {63'h0, resp_fault}, 64'h1);
    chk("R8", "level-2 fault lvl", {62'h0, resp_fault_lvl}, 64'h2);
    chk("R8", "level-2 reads", 64'(rd_cnt), 64'd2);
    take_resp("R10");
    // level 3 invalid: entry present but valid bit clear
    mem[eaddr(28'h400, 9'd7)] = ent(1'b0, 1'b1, 28'h1111111);
    walk(8'd5, mkva(9'd3, 9'd4, 9'd7, 12'h0), lat);
    chk("R8", "level-3 fault lvl", {62'h0, resp_fault_lvl}, 64'h3);
    chk("R8", "level-3 reads", 64'(rd_cnt), 64'd3);
    chk("R8", "level-3 fault pa", {24'h0, resp_pa}, 64'h0);
    take_resp("R10");
  endtask

  task automatic t_stall;
    int lat;
    logic [39:0] held;
    walk(8'd9, mkva(9'd1, 9'd0, 9'd0, 12'h123), lat);
    held = resp_pa;
    rd_cnt = 0;
    req_valid = 1'b1; req_task = 8'd5; req_va = mkva(9'd7, 9'd8, 9'd0, 12'h0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10", "held pa", {24'h0, resp_pa}, {24'h0, held});
      chk("R10", "no accept while held", {63'h0, req_ready}, 64'h0);
    end
    req_valid = 1'b0;
    chk("R10", "no reads while held", 64'(rd_cnt), 64'd0);
    take_resp("R10");
  endtask

  task automatic t_same_cycle;
    int lat;
    logic [38:0] v = mkva(9'd1, 9'd2, 9'd3, 12'h456);
    mem[eaddr(28'h600, 9'd1)] = ent(1'b1, 1'b1, 28'h2468ACE);
    @(negedge clk);
    rd_cnt = 0;
    req_valid = 1'b1; req_task = 8'd9; req_va = v;
    root_we = 1'b1; root_task = 8'd9; root_ppn = 28'h600;
    @(negedge clk);
    req_valid = 1'b0; root_we = 1'b0;
    lat = 0;
    while (!resp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk("R11", "same-edge uses old root", {24'h0, resp_pa},
        {24'h0, 28'h7654321 >> 18, v[29:0]});
    take_resp("R10");
    walk(8'd9, v, lat);
    chk("R11", "next request uses new root", {24'h0, resp_pa},
        {24'h0, 10'(28'h2468ACE >> 18), v[29:0]});
    chk("R2", "new root huge size", {62'h0, resp_size}, 64'h2);
    take_resp("R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    root_we = 1'b0; root_task = '0; root_ppn = '0;
    req_valid = 1'b0; req_task = '0; req_va = '0;
    resp_ready = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    set_root(8'd5, 28'h100);
    set_root(8'd9, 28'h200);
    t_small();
    t_big();
    t_huge();
    t_faults();
    t_stall();
    t_same_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule